// File: doc/BRIEF.md
# PC-relative immediate load unit

This unit executes the three move-immediate instructions of a 32-bit RISC core with 16-bit instruction words. It receives one instruction word together with the address from which it was fetched. It also receives a delay-slot flag and a branch-target address. The short-immediate form needs no memory access. It sign-extends its 8-bit constant and drives the register write port. The two literal-table forms build a PC-relative byte address, make one read on a request/acknowledge data port, extend the returned data and write the result to the destination register.

The data port is big-endian. A read always returns the aligned 32-bit longword that contains the requested address. For a 16-bit read, the unit selects the correct half of that longword. Wait states can be any length, and the unit holds the request until the memory acknowledges it. Only one instruction is in flight at a time. The `busy` output tells the issuing stage when the unit will not accept a new instruction. None of the three forms touches the condition flag, so the unit has no flag port.

Top module: `pcrel_imm_unit`

## Requirements
- R1: An instruction whose top nibble is 1110 is accepted while idle. In the next cycle `wr_en` is high for one cycle, with `wr_idx` = bits 11:8 and `wr_data` = bits 7:0 sign-extended to 32 bits (bit 7 set gives ones in bits 31:8). No memory request is made and `busy` stays low.
- R2: An instruction whose top nibble is 1001 (word form) raises `mem_req` in the cycle after it is accepted. It presents `mem_size` = 0 and `mem_addr` = base + 2 × d, where d is bits 7:0 zero-extended.
- R3: An instruction whose top nibble is 1101 (longword form) raises `mem_req` in the cycle after it is accepted. It presents `mem_size` = 1 and `mem_addr` = (base with bits 1:0 cleared) + 4 × d. This address is always a multiple of 4.
- R4: With `in_slot` low, base is `in_addr` + 4. With `in_slot` high, base is `in_target` + 2.
- R5: `mem_req`, `mem_addr` and `mem_size` stay unchanged until a clock edge at which `mem_ack` is high. `mem_req` drops after that edge.
- R6: For the word form, the 16-bit value is taken from `mem_rdata[31:16]` when `mem_addr[1]` is 0, and from `mem_rdata[15:0]` when it is 1. That value is sign-extended to 32 bits and written to register n in the cycle after the acknowledge.
- R7: For the longword form, `mem_rdata` is written unchanged to register n (bits 11:8) in the cycle after the acknowledge.
- R8: After a memory form, `wr_en` is high for exactly one cycle. `busy` is high from the first cycle of `mem_req` through the write cycle, and low in the cycle after the write.
- R9: Any other top nibble gives a one-cycle `unhandled` pulse in the cycle after acceptance, with no register write and no memory request.
- R10: `in_valid` is ignored while `busy` is high. Such an instruction produces no write and no request.
- R11: While `rst` is high and in the cycle after, `busy`, `mem_req`, `wr_en` and `unhandled` are low.
- R12: d = 255 reaches base + 510 for the word form and aligned base + 1020 for the longword form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present, taken when idle |
| in_instr | input | 16 | Instruction word |
| in_addr | input | 32 | Fetch address of the instruction |
| in_slot | input | 1 | Instruction sits in a branch delay slot |
| in_target | input | 32 | Branch target address used when in_slot is high |
| busy | output | 1 | Unit cannot accept an instruction |
| unhandled | output | 1 | One-cycle pulse for an opcode this unit does not execute |
| mem_req | output | 1 | Data read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_size | output | 1 | 0 = 16-bit read, 1 = 32-bit read |
| mem_ack | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Aligned big-endian longword containing mem_addr |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Destination register number |
| wr_data | output | 32 | Value written to the register |

## Verification
The assertions assume that `mem_ack` is high only while `mem_req` is high. The memory model in the bench answers only a pending request, and it drops the acknowledge in the cycle after the one it raised. The assertions also assume that `in_addr` and `in_target` are even, since instruction words are halfword aligned. Every fetch and target address that the bench drives is even, so every word-form address stays halfword aligned. The bench varies the wait states from zero to three, so both the held request and the immediate acknowledge are exercised.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  typedef enum logic [1:0] {
    K_NONE,
    K_IMM,
    K_WORD,
    K_LONG
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WB
  } state_e;

  localparam logic [3:0] NIB_IMM  = 4'hE;
  localparam logic [3:0] NIB_WORD = 4'h9;
  localparam logic [3:0] NIB_LONG = 4'hD;

  localparam logic SZ_WORD = 1'b0;
  localparam logic SZ_LONG = 1'b1;

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 4,
  parameter int FIELD_W = 8
) (
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind,
  output logic [IDX_W-1:0]   idx,
  output logic [FIELD_W-1:0] field
);
  localparam int OP_W = INSTR_W - IDX_W - FIELD_W;

  logic [OP_W-1:0] op;

  assign op    = instr[INSTR_W-1 -: OP_W];
  assign idx   = instr[FIELD_W +: IDX_W];
  assign field = instr[FIELD_W-1:0];

  always_comb begin
    kind = K_NONE;
    if (op == OP_W'(NIB_IMM))       kind = K_IMM;
    else if (op == OP_W'(NIB_WORD)) kind = K_WORD;
    else if (op == OP_W'(NIB_LONG)) kind = K_LONG;
  end
endmodule

// File: rtl/pcrel_agen.sv
module pcrel_agen
  import pcrel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 8
) (
  input  kind_e              kind,
  input  logic [ADDR_W-1:0]  pc,
  input  logic               slot,
  input  logic [ADDR_W-1:0]  target,
  input  logic [FIELD_W-1:0] disp,
  output logic [ADDR_W-1:0]  ea
);
  localparam logic [ADDR_W-1:0] SEQ_OFS   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SLOT_OFS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] disp_z;

  assign base   = slot ? (target + SLOT_OFS) : (pc + SEQ_OFS);
  assign disp_z = ADDR_W'(disp);

  always_comb begin
    if (kind == K_LONG) ea = (base & ALIGN_MSK) + (disp_z << 2);
    else                ea = base + (disp_z << 1);
  end
endmodule

// File: rtl/pcrel_extend.sv
module pcrel_extend #(
  parameter int DATA_W = 32
) (
  input  logic              is_long,
  input  logic              lane_lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] half;

  assign half  = lane_lo ? rdata[HALF_W-1:0] : rdata[DATA_W-1 -: HALF_W];
  assign wdata = is_long ? rdata : {{HALF_W{half[HALF_W-1]}}, half};
endmodule

// File: rtl/pcrel_imm_unit.sv
module pcrel_imm_unit
  import pcrel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic               in_slot,
  input  logic [ADDR_W-1:0]  in_target,
  output logic               busy,
  output logic               unhandled,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_size,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data
);
  localparam int FIELD_W = INSTR_W / 2;

  state_e             state;
  kind_e              dec_kind;
  logic [IDX_W-1:0]   dec_idx;
  logic [FIELD_W-1:0] dec_field;
  logic [ADDR_W-1:0]  calc_ea;
  logic [DATA_W-1:0]  ext_data;
  logic [DATA_W-1:0]  imm_data;

  pcrel_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_dec (
    .instr (in_instr),
    .kind  (dec_kind),
    .idx   (dec_idx),
    .field (dec_field)
  );

  pcrel_agen #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_agen (
    .kind   (dec_kind),
    .pc     (in_addr),
    .slot   (in_slot),
    .target (in_target),
    .disp   (dec_field),
    .ea     (calc_ea)
  );

  pcrel_extend #(.DATA_W(DATA_W)) u_ext (
    .is_long (mem_size),
    .lane_lo (mem_addr[1]),
    .rdata   (mem_rdata),
    .wdata   (ext_data)
  );

  assign imm_data = {{(DATA_W-FIELD_W){dec_field[FIELD_W-1]}}, dec_field};
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= SZ_WORD;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      unhandled <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      unhandled <= 1'b0;
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            case (dec_kind)
              K_IMM: begin
                wr_en   <= 1'b1;
                wr_idx  <= dec_idx;
                wr_data <= imm_data;
              end
              K_WORD, K_LONG: begin
                state    <= S_REQ;
                mem_req  <= 1'b1;
                mem_addr <= calc_ea;
                mem_size <= (dec_kind == K_LONG) ? SZ_LONG : SZ_WORD;
                wr_idx   <= dec_idx;
              end
              default: unhandled <= 1'b1;
            endcase
          end
        end
        S_REQ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            wr_en   <= 1'b1;
            wr_data <= ext_data;
            state   <= S_WB;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcrel_imm_unit_chk.sv
module pcrel_imm_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              unhandled,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_size,
  input logic              mem_ack,
  input logic              wr_en
);
  p_long_align_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

  p_wr_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (wr_en && !mem_req));

  p_wb_single_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (!wr_en && !busy));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_busy_starts_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_req);

  p_unh_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!wr_en && !mem_req));

  p_accept_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!busy));
endmodule

bind pcrel_imm_unit pcrel_imm_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .unhandled (unhandled),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_ack   (mem_ack),
  .wr_en     (wr_en)
);

// File: tb/pcrel_imm_unit_test.sv
module pcrel_imm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = '0;
  logic [31:0] in_addr = '0;
  logic        in_slot = 1'b0;
  logic [31:0] in_target = '0;
  logic        busy, unhandled, mem_req, mem_size, wr_en;
  logic [31:0] mem_addr, wr_data;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  wr_idx;

  int total = 0;
  int bad = 0;
  int latency = 0;
  int wcnt = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pcrel_imm_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_addr(in_addr), .in_slot(in_slot), .in_target(in_target),
    .busy(busy), .unhandled(unhandled), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] w;
    w = {2'b00, a[31:2]};
    return (w * 32'h0100_0193) ^ {a[3], 15'h2A5C, a[2], 15'h5A3C};
  endfunction

  function automatic logic [31:0] exp_ea(input bit lng, input bit slot,
      input logic [31:0] pc, input logic [31:0] tgt, input logic [7:0] d);
    logic [31:0] base;
    base = slot ? tgt + 32'd2 : pc + 32'd4;
    if (lng) return {base[31:2], 2'b00} + {22'd0, d, 2'b00};
    return base + {23'd0, d, 1'b0};
  endfunction

  function automatic logic [31:0] exp_data(input bit lng, input logic [31:0] ea);
    logic [31:0] w;
    logic [15:0] h;
    w = word_at(ea);
    h = ea[1] ? w[15:0] : w[31:16];
    return lng ? w : {{16{h[15]}}, h};
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= latency) begin
        mem_ack   <= 1'b1;
        mem_rdata <= word_at(mem_addr);
        wcnt      <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !mem_req && !wr_en && !unhandled, "R11", "outputs in reset",
        {28'd0, busy, mem_req, wr_en, unhandled}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !wr_en && !unhandled, "R11", "outputs after reset",
        {28'd0, busy, mem_req, wr_en, unhandled}, 32'd0);
  endtask

  task automatic t_imm(input logic [3:0] n, input logic [7:0] imm);
    logic [31:0] e;
    e = {{24{imm[7]}}, imm};
    in_instr = {4'hE, n, imm};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(wr_en && wr_idx == n, "R1", "imm write strobe/index", {27'd0, wr_en, wr_idx}, {27'd1, n});
    chk(wr_data == e, "R1", "imm sign extension", wr_data, e);
    chk(!mem_req && !busy, "R1", "imm no request", {30'd0, mem_req, busy}, 32'd0);
    @(negedge clk);
    chk(!wr_en, "R1", "imm single write", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_imm_b2b();
    in_instr = 16'hE27F;
    in_valid = 1'b1;
    @(negedge clk);
    in_instr = 16'hE580;
    chk(wr_en && wr_idx == 4'd2 && wr_data == 32'h7F, "R1", "first back-to-back imm", wr_data, 32'h7F);
    @(negedge clk);
    in_valid = 1'b0;
    chk(wr_en && wr_idx == 4'd5 && wr_data == 32'hFFFF_FF80, "R1", "second back-to-back imm",
        wr_data, 32'hFFFF_FF80);
    @(negedge clk);
  endtask

  task automatic t_mem(input bit lng, input bit slot, input logic [31:0] pc,
                       input logic [31:0] tgt, input logic [3:0] n,
                       input logic [7:0] d, input int lat, input string tag);
    logic [31:0] ea, ed;
    int k;
    ea = exp_ea(lng, slot, pc, tgt, d);
    ed = exp_data(lng, ea);
    latency = lat;
    in_instr  = {lng ? 4'hD : 4'h9, n, d};
    in_addr   = pc;
    in_slot   = slot;
    in_target = tgt;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_slot  = 1'b0;
    chk(mem_req && busy, tag, "request and busy after accept", {30'd0, mem_req, busy}, 32'd3);
    chk(mem_addr == ea, tag, "effective address", mem_addr, ea);
    chk(mem_size == lng, tag, "size code", {31'd0, mem_size}, {31'd0, lng});
    k = 0;
    while (!wr_en && k < 20) begin
      @(negedge clk);
      k++;
      if (!wr_en)
        chk(mem_req && mem_addr == ea && busy, "R5", "request held while waiting", mem_addr, ea);
    end
    chk(wr_en && wr_idx == n, lng ? "R7" : "R6", "write index", {27'd0, wr_en, wr_idx}, {27'd1, n});
    chk(wr_data == ed, lng ? "R7" : "R6", "written data", wr_data, ed);
    chk(busy && !mem_req, "R8", "busy during write", {30'd0, busy, mem_req}, 32'd2);
    @(negedge clk);
    chk(!wr_en && !busy, "R8", "single write then idle", {30'd0, wr_en, busy}, 32'd0);
  endtask

  task automatic t_unhandled(input logic [3:0] op);
    in_instr = {op, 12'h3C5};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(unhandled && !wr_en && !mem_req, "R9", "unhandled pulse only",
        {29'd0, unhandled, wr_en, mem_req}, 32'd4);
    @(negedge clk);
    chk(!unhandled && !busy && !wr_en && !mem_req, "R9", "unhandled clears, nothing issued",
        {28'd0, unhandled, busy, wr_en, mem_req}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] ea;
    int k;
    ea = exp_ea(1'b1, 1'b0, 32'h4000, 32'h0, 8'd1);
    latency  = 3;
    in_instr = 16'hD501;
    in_addr  = 32'h4000;
    in_valid = 1'b1;
    @(negedge clk);
    in_instr = 16'hE912;
    k = 0;
    while (!wr_en && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(wr_idx == 4'd5 && wr_data == exp_data(1'b1, ea), "R10", "busy instruction not taken",
        wr_data, exp_data(1'b1, ea));
    in_valid = 1'b0;
    @(negedge clk);
    chk(!wr_en && !mem_req && !busy, "R10", "no late write or request",
        {29'd0, wr_en, mem_req, busy}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_imm(4'd3, 8'h7F);
    t_imm(4'd10, 8'h80);
    t_imm(4'd0, 8'hFF);
    t_imm(4'd15, 8'h00);
    t_imm_b2b();
    t_mem(1'b0, 1'b0, 32'h1000, 32'h0, 4'd1, 8'h10, 0, "R2");
    t_mem(1'b0, 1'b0, 32'h1000, 32'h0, 4'd2, 8'h11, 2, "R2");
    t_mem(1'b0, 1'b0, 32'h1002, 32'h0, 4'd4, 8'h21, 1, "R6");
    t_mem(1'b1, 1'b0, 32'h2002, 32'h0, 4'd6, 8'h03, 0, "R3");
    t_mem(1'b1, 1'b0, 32'h2000, 32'h0, 4'd7, 8'h40, 3, "R3");
    t_mem(1'b0, 1'b0, 32'h1002, 32'h0, 4'd8, 8'hFF, 1, "R12");
    t_mem(1'b1, 1'b0, 32'h2000, 32'h0, 4'd9, 8'hFF, 0, "R12");
    t_mem(1'b0, 1'b1, 32'h5000, 32'h3000, 4'd11, 8'h01, 1, "R4");
    t_mem(1'b1, 1'b1, 32'h5000, 32'h3002, 4'd12, 8'h02, 2, "R4");
    t_unhandled(4'h0);
    t_unhandled(4'hF);
    t_unhandled(4'hA);
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule